// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a 32-bit virtual address into a 30-bit physical address through a small table of per-segment relocation entries. The two most significant address bits pick one of four entries; the remaining 30 bits form an offset. The offset is tested against the selected entry's bound. If it passes, the offset is added to the entry's base to form the physical address. If it fails, the block reports a fault instead of an address.

Requests arrive on a valid/ready handshake. Each accepted request produces one registered response on a second valid/ready handshake, carrying either a physical address or a fault flag. A separate write port loads the base and bound of any entry, so software can place or move a segment by rewriting that entry.

Top module: `segmap_xlate`

## Requirements
- R1: Bits [31:30] of `req_vaddr` select the table entry (value n selects entry n). Bits [29:0] form the offset.
- R2: When the offset is strictly less than the selected bound, and base plus offset fits in 30 bits, the response carries `rsp_fault`=0 and `rsp_paddr` = base + offset. The bound is the segment length in bytes.
- R3: When the offset is greater than or equal to the selected bound, the response carries `rsp_fault`=1 and `rsp_paddr`=0.
- R4: When base plus offset reaches 2^30 or more, the response carries `rsp_fault`=1 and `rsp_paddr`=0.
- R5: After reset, every bound is zero, so every request faults. In the same state `rsp_valid` is 0 and `req_ready` is 1.
- R6: A cycle with `cfg_we`=1 writes `cfg_base` and `cfg_bound` into entry `cfg_idx` at that clock edge. A request accepted at that same edge still uses the old contents. Requests accepted at later edges use the new contents.
- R7: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) has its response on the outputs with `rsp_valid`=1 right after that edge.
- R8: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0, and `rsp_valid`, `rsp_paddr` and `rsp_fault` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write enable |
| cfg_idx | input | 2 | Entry to write |
| cfg_base | input | 30 | Physical base for the entry |
| cfg_bound | input | 30 | Segment length for the entry |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 30 | Physical address, zero on a fault |
| rsp_fault | output | 1 | Bound or range fault |

## Verification
A vector table sends addresses to all four segments. Each segment has a different base, so a wrong segment choice shows up as a wrong address. Offsets are placed at zero, at one below the bound and exactly at the bound; these separate a strict comparison from an inclusive one. One segment has a base close to the top of memory, which separates a correct carry check from a truncated sum. Directed tests cover the all-fault state after reset, relocation followed by a write in the same cycle as a request (which separates old table contents from new), and a stalled response that must not be replaced by a waiting request.

// File: rtl/segmap_pkg.sv
package segmap_pkg;
  localparam int VA_W     = 32;
  localparam int PA_W     = 30;
  localparam int SEG_BITS = 2;
  localparam int NSEG     = 1 << SEG_BITS;
  localparam int OFF_W    = VA_W - SEG_BITS;
  localparam int SUM_W    = ((OFF_W > PA_W) ? OFF_W : PA_W) + 1;

  // segment field of a virtual address
  function automatic logic [SEG_BITS-1:0] va_seg(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: SEG_BITS];
  endfunction

  // offset field of a virtual address
  function automatic logic [OFF_W-1:0] va_off(input logic [VA_W-1:0] va);
    return va[OFF_W-1:0];
  endfunction

  // widened sum so that a carry past PA_W bits is visible
  function automatic logic [SUM_W-1:0] reloc_sum(input logic [PA_W-1:0] base,
                                                 input logic [OFF_W-1:0] off);
    return SUM_W'(base) + SUM_W'(off);
  endfunction
endpackage

// File: rtl/segmap_table.sv
module segmap_table
  import segmap_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEG_BITS-1:0] wr_idx,
  input  logic [PA_W-1:0]     wr_base,
  input  logic [OFF_W-1:0]    wr_bound,
  input  logic [SEG_BITS-1:0] rd_idx,
  output logic [PA_W-1:0]     rd_base,
  output logic [OFF_W-1:0]    rd_bound
);
  logic [PA_W-1:0]  base_q  [NSEG];
  logic [OFF_W-1:0] bound_q [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_idx == SEG_BITS'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        bound_q[g] <= '0;
      end else if (hit) begin
        base_q[g]  <= wr_base;
        bound_q[g] <= wr_bound;
      end
    end
  end

  assign rd_base  = base_q[rd_idx];
  assign rd_bound = bound_q[rd_idx];

  // R6
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && rd_idx == wr_idx |=> $past(rd_idx) != rd_idx || rd_bound == $past(wr_bound));
endmodule

// File: rtl/segmap_check.sv
module segmap_check
  import segmap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  base,
  input  logic [OFF_W-1:0] bound,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  paddr,
  output logic             fault
);
  logic [SUM_W-1:0] sum;
  logic             in_bound;
  logic             carry_out;

  assign sum       = reloc_sum(base, off);
  assign in_bound  = off < bound;
  assign carry_out = |(sum >> PA_W);
  assign fault     = !in_bound || carry_out;
  assign paddr     = fault ? '0 : sum[PA_W-1:0];

  // R2
  pass_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> (SUM_W'(paddr) >= SUM_W'(base)) && (off < bound));
endmodule

// File: rtl/segmap_xlate.sv
module segmap_xlate
  import segmap_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SEG_BITS-1:0] cfg_idx,
  input  logic [PA_W-1:0]     cfg_base,
  input  logic [OFF_W-1:0]    cfg_bound,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VA_W-1:0]     req_vaddr,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [PA_W-1:0]     rsp_paddr,
  output logic                rsp_fault
);
  logic [PA_W-1:0]  sel_base;
  logic [OFF_W-1:0] sel_bound;
  logic [PA_W-1:0]  xl_paddr;
  logic             xl_fault;
  logic             accept;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  segmap_table u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_idx),
    .wr_base  (cfg_base),
    .wr_bound (cfg_bound),
    .rd_idx   (va_seg(req_vaddr)),
    .rd_base  (sel_base),
    .rd_bound (sel_bound)
  );

  segmap_check u_check (
    .clk   (clk),
    .rst_n (rst_n),
    .base  (sel_base),
    .bound (sel_bound),
    .off   (va_off(req_vaddr)),
    .paddr (xl_paddr),
    .fault (xl_fault)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_paddr <= xl_paddr;
      rsp_fault <= xl_fault;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R3
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0);

  // R7
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
endmodule

// File: tb/segmap_xlate_bench.sv
module segmap_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [29:0] cfg_base = '0;
  logic [29:0] cfg_bound = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [29:0] rsp_paddr;
  logic        rsp_fault;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  segmap_xlate u_segmap_xlate (.*);

  localparam int NV = 9;
  localparam logic [31:0] V_VA [NV] = '{
    32'h0000_0000, 32'h0000_06FF, 32'h0000_0700, 32'h4000_0123, 32'h8000_0200,
    32'h8000_1000, 32'hC000_0FFF, 32'hC000_1000, 32'hBFFF_FFFF};
  localparam logic [29:0] V_PA [NV] = '{
    30'h4000, 30'h46FF, 30'h0, 30'h123, 30'h2200,
    30'h0, 30'h3FFF_FFFF, 30'h0, 30'h0};
  localparam bit V_F [NV] = '{0, 0, 1, 0, 0, 1, 0, 1, 1};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [29:0] b, input logic [29:0] bd);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_base = b; cfg_bound = bd;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one accepted request; response sampled at the following negedge
  task automatic xl(input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    check("R5 rsp_valid", 32'(rsp_valid), 0);
    check("R5 req_ready", 32'(req_ready), 1);
    xl(32'h8000_0000);
    check("R5 fault", 32'(rsp_fault), 1);
    check("R5 paddr", 32'(rsp_paddr), 0);
    check("R7 valid", 32'(rsp_valid), 1);

    wr(2'd0, 30'h4000, 30'h700);
    wr(2'd1, 30'h0, 30'h500);
    wr(2'd2, 30'h2000, 30'h1000);
    wr(2'd3, 30'h3FFF_F000, 30'h2000);

    // R1 R2 R3 R4 vector walk
    for (int i = 0; i < NV; i++) begin
      xl(V_VA[i]);
      check("R1/R2 paddr", 32'(rsp_paddr), 32'(V_PA[i]));
      check("R3/R4 fault", 32'(rsp_fault), 32'(V_F[i]));
    end

    // R6 relocation
    wr(2'd2, 30'h8000, 30'h1000);
    xl(32'h8000_0200);
    check("R6 relocated", 32'(rsp_paddr), 32'h8200);

    // R6 write in the same cycle as an accepted request
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd2; cfg_base = 30'h9000; cfg_bound = 30'h1000;
    req_valid = 1'b1; req_vaddr = 32'h8000_0200;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R6 old contents", 32'(rsp_paddr), 32'h8200);
    xl(32'h8000_0200);
    check("R6 new contents", 32'(rsp_paddr), 32'h9200);

    // R8 back-pressure
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h4000_0010; rsp_ready = 1'b0;
    @(negedge clk);
    req_vaddr = 32'h4000_0020;
    check("R8 req_ready low", 32'(req_ready), 0);
    @(negedge clk);
    check("R8 held paddr", 32'(rsp_paddr), 32'h10);
    check("R8 held valid", 32'(rsp_valid), 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 next response", 32'(rsp_paddr), 32'h20);
    @(negedge clk);
    check("R7 drained", 32'(rsp_valid), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule